// File: doc/BRIEF.md
# Host Block Transfer Controller

This block streams a run of bytes out of a shared buffer memory to a host that reads over an 8-bit bus. A control processor programs a byte count and a start address through a small register port, then writes a trigger register. From the next cycle the block holds its transfer-enable output low. Each host read strobe then takes the next byte in address order. When the host strobes faster than memory can deliver, the block pulls a wait line low. It marks the final byte with an end-of-transfer flag, and it raises an interrupt to the processor once that byte has gone.

A mode pin selects between two host handshakes. In strobe mode the host reads freely inside the enable window. In request mode the block raises a data request whenever a byte is ready, and the host answers with a read strobe, in the manner of a DMA engine. One byte is always fetched ahead into a holding register, so wait states only appear while that fetch is still outstanding. The memory side is a single read port: the address is held with a request until a valid pulse returns the data.

Top module: `hxfer_ctrl`

## Requirements
- R1: After reset xfer_en_n, host_wait_n are 1 and busy, irq, drq, eop, mem_req are 0.
- R2: Register select codes are 0 count bits [7:0], 1 count bits [11:8] (wdata[3:0]), 2 address bits [7:0], 3 address bits [15:8], 4 trigger (data ignored), 5 interrupt acknowledge. A trigger write while idle starts a transfer of count+1 bytes; from the next cycle busy is 1 and xfer_en_n is 0.
- R3: The k-th byte delivered (k from 0) is the memory byte at start address + k, with the address wrapping modulo 2^16.
- R4: While busy, host_rd is high and the next byte is not yet held, host_wait_n is 0; the byte appears on host_data in the first cycle of the strobe with host_wait_n 1. With a zero-latency memory and at least one idle cycle between strobes, no wait state occurs after the first byte.
- R5: One strobe takes exactly one byte however long host_rd stays high; after delivery, host_wait_n stays 1 and eop 0 until host_rd falls.
- R6: eop is 1 exactly in the cycles of the strobe of the last counted byte up to and including its delivery cycle.
- R7: In the cycle after the last byte is delivered, busy is 0, xfer_en_n is 1 and irq is 1.
- R8: irq stays 1 until a write to select 5, and is 0 from the next cycle.
- R9: A trigger write while busy is ignored: the running transfer keeps its count and address.
- R10: drq is 1 only when drq_mode is 1, busy is 1, a byte is held and host_rd is 0; in strobe mode drq is always 0.
- R11: mem_req is only raised while busy; its address is stable until mem_valid; a transfer issues exactly count+1 memory reads.
- R12: host_rd while idle is ignored: no memory read, host_wait_n stays 1 and eop 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Processor register write strobe |
| reg_sel | input | 3 | Register select code |
| reg_wdata | input | 8 | Register write data |
| irq | output | 1 | Transfer-complete interrupt |
| busy | output | 1 | Transfer in progress |
| drq_mode | input | 1 | 1 selects request handshake, 0 strobe handshake |
| host_rd | input | 1 | Host read strobe, active high |
| host_data | output | 8 | Byte returned to the host |
| host_wait_n | output | 1 | Active-low wait, host must hold its strobe |
| xfer_en_n | output | 1 | Active-low transfer window |
| drq | output | 1 | Data request in request mode |
| eop | output | 1 | Last-byte marker |
| mem_req | output | 1 | Buffer read request |
| mem_addr | output | 16 | Buffer read address |
| mem_valid | input | 1 | Read data valid, completes the request |
| mem_rdata | input | 8 | Buffer read data |

## Verification
The hardest situation to reach is a host strobe that arrives while the prefetch is still outstanding, combined with the last-byte flag, since a fast memory hides it entirely. The stimulus forces it with a directed run whose memory latency is fixed at several cycles and whose first strobe follows the trigger at once, and with random runs that mix memory latency, strobe gaps and strobe hold times in both handshake modes. A trigger issued mid-transfer with a fresh count, a one-byte transfer, an address wrap and a full 4096-byte count complete the corners.

// File: rtl/hxfer_pkg.sv
package hxfer_pkg;

    typedef enum logic [2:0] {
        SEL_CNT_LO = 3'd0,
        SEL_CNT_HI = 3'd1,
        SEL_ADR_LO = 3'd2,
        SEL_ADR_HI = 3'd3,
        SEL_TRIG   = 3'd4,
        SEL_ACK    = 3'd5
    } reg_sel_e;

    typedef struct packed {
        logic running;
        logic served;
    } host_state_t;

    function automatic logic sel_is(input logic we, input logic [2:0] sel, input reg_sel_e code);
        return we && (sel == code);
    endfunction

endpackage

// File: rtl/hxfer_regs.sv
module hxfer_regs
    import hxfer_pkg::*;
#(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    input  logic              busy,
    input  logic              done,
    output logic              start,
    output logic [CNT_W-1:0]  cnt_cfg,
    output logic [ADDR_W-1:0] adr_cfg,
    output logic              irq
);
    localparam int CNT_HI_W = CNT_W - 8;
    localparam int ADR_HI_W = ADDR_W - 8;

    assign start = sel_is(reg_we, reg_sel, SEL_TRIG) && !busy;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_cfg <= '0;
            adr_cfg <= '0;
            irq     <= 1'b0;
        end else begin
            if (sel_is(reg_we, reg_sel, SEL_CNT_LO)) cnt_cfg[7:0] <= reg_wdata;
            if (sel_is(reg_we, reg_sel, SEL_CNT_HI)) cnt_cfg[CNT_W-1:8] <= reg_wdata[CNT_HI_W-1:0];
            if (sel_is(reg_we, reg_sel, SEL_ADR_LO)) adr_cfg[7:0] <= reg_wdata;
            if (sel_is(reg_we, reg_sel, SEL_ADR_HI)) adr_cfg[ADDR_W-1:8] <= reg_wdata[ADR_HI_W-1:0];
            if (done)
                irq <= 1'b1;
            else if (sel_is(reg_we, reg_sel, SEL_ACK))
                irq <= 1'b0;
        end
    end
endmodule

// File: rtl/hxfer_fetch.sv
module hxfer_fetch #(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  cnt_cfg,
    input  logic [ADDR_W-1:0] adr_cfg,
    input  logic              running,
    input  logic              consume,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              hold_valid,
    output logic [DATA_W-1:0] hold_data
);
    localparam int LEFT_W = CNT_W + 1;

    logic [LEFT_W-1:0] left_q;
    logic [ADDR_W-1:0] addr_q;

    assign mem_req  = running && !hold_valid && (left_q != '0);
    assign mem_addr = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            left_q     <= '0;
            addr_q     <= '0;
            hold_valid <= 1'b0;
            hold_data  <= '0;
        end else if (start) begin
            left_q     <= LEFT_W'(cnt_cfg) + LEFT_W'(1);
            addr_q     <= adr_cfg;
            hold_valid <= 1'b0;
        end else if (mem_req && mem_valid) begin
            hold_data  <= mem_rdata;
            hold_valid <= 1'b1;
            addr_q     <= addr_q + ADDR_W'(1);
            left_q     <= left_q - LEFT_W'(1);
        end else if (consume) begin
            hold_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/hxfer_hostif.sv
module hxfer_hostif
    import hxfer_pkg::*;
#(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CNT_W-1:0] cnt_cfg,
    input  logic             drq_mode,
    input  logic             host_rd,
    input  logic             hold_valid,
    output logic             running,
    output logic             consume,
    output logic             done,
    output logic             host_wait_n,
    output logic             eop,
    output logic             drq
);
    localparam int LEFT_W = CNT_W + 1;

    host_state_t       st;
    logic [LEFT_W-1:0] left_q;
    logic              pending;
    logic              last;

    assign running     = st.running;
    assign pending     = st.running && host_rd && !st.served;
    assign last        = (left_q == LEFT_W'(1));
    assign consume     = pending && hold_valid;
    assign done        = consume && last;
    assign host_wait_n = !(pending && !hold_valid);
    assign eop         = pending && last;
    assign drq         = drq_mode && st.running && hold_valid && !host_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            st     <= '0;
            left_q <= '0;
        end else if (start) begin
            st.running <= 1'b1;
            st.served  <= 1'b0;
            left_q     <= LEFT_W'(cnt_cfg) + LEFT_W'(1);
        end else if (consume) begin
            st.served <= 1'b1;
            left_q    <= left_q - LEFT_W'(1);
            if (last) st.running <= 1'b0;
        end else if (!host_rd) begin
            st.served <= 1'b0;
        end
    end
endmodule

// File: rtl/hxfer_ctrl.sv
module hxfer_ctrl #(
    parameter int CNT_W  = 12,
    parameter int ADDR_W = 16,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              reg_we,
    input  logic [2:0]        reg_sel,
    input  logic [7:0]        reg_wdata,
    output logic              irq,
    output logic              busy,
    input  logic              drq_mode,
    input  logic              host_rd,
    output logic [DATA_W-1:0] host_data,
    output logic              host_wait_n,
    output logic              xfer_en_n,
    output logic              drq,
    output logic              eop,
    output logic              mem_req,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic              mem_valid,
    input  logic [DATA_W-1:0] mem_rdata
);
    logic              start;
    logic              running;
    logic              consume;
    logic              done;
    logic              hold_valid;
    logic [CNT_W-1:0]  cnt_cfg;
    logic [ADDR_W-1:0] adr_cfg;

    assign busy      = running;
    assign xfer_en_n = !running;

    hxfer_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
        .clk(clk), .rst(rst), .reg_we(reg_we), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .busy(running), .done(done), .start(start),
        .cnt_cfg(cnt_cfg), .adr_cfg(adr_cfg), .irq(irq)
    );

    hxfer_fetch #(.CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fetch (
        .clk(clk), .rst(rst), .start(start), .cnt_cfg(cnt_cfg),
        .adr_cfg(adr_cfg), .running(running), .consume(consume),
        .mem_valid(mem_valid), .mem_rdata(mem_rdata), .mem_req(mem_req),
        .mem_addr(mem_addr), .hold_valid(hold_valid), .hold_data(host_data)
    );

    hxfer_hostif #(.CNT_W(CNT_W)) u_host (
        .clk(clk), .rst(rst), .start(start), .cnt_cfg(cnt_cfg),
        .drq_mode(drq_mode), .host_rd(host_rd), .hold_valid(hold_valid),
        .running(running), .consume(consume), .done(done),
        .host_wait_n(host_wait_n), .eop(eop), .drq(drq)
    );
endmodule

// File: rtl/hxfer_ctrl_chk.sv
module hxfer_ctrl_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst,
    input logic              reg_we,
    input logic [2:0]        reg_sel,
    input logic              irq,
    input logic              busy,
    input logic              drq_mode,
    input logic              host_rd,
    input logic              host_wait_n,
    input logic              drq,
    input logic              eop,
    input logic              mem_req,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              mem_valid
);
    p_start_by_trigger_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> $past(reg_we && reg_sel == 3'd4));

    p_wait_only_busy_r4: assert property (@(posedge clk) disable iff (rst)
        !host_wait_n |-> busy && host_rd);

    p_eop_in_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        eop |-> busy && host_rd);

    p_irq_at_end_r7: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> irq);

    p_ack_clears_r8: assert property (@(posedge clk) disable iff (rst)
        (reg_we && reg_sel == 3'd5 && !busy) |=> !irq);

    p_drq_gated_r10: assert property (@(posedge clk) disable iff (rst)
        drq |-> drq_mode && busy && !host_rd);

    p_req_only_busy_r11: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy);

    p_addr_held_r11: assert property (@(posedge clk) disable iff (rst)
        (mem_req && !mem_valid) |=> mem_req && $stable(mem_addr));
endmodule

bind hxfer_ctrl hxfer_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (.*);

// File: tb/hxfer_ctrl_tb.sv
`timescale 1ns/1ps
module hxfer_ctrl_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        reg_we = 1'b0;
    logic [2:0]  reg_sel = '0;
    logic [7:0]  reg_wdata = '0;
    logic        irq, busy;
    logic        drq_mode = 1'b0;
    logic        host_rd = 1'b0;
    logic [7:0]  host_data;
    logic        host_wait_n, xfer_en_n, drq, eop, mem_req;
    logic [15:0] mem_addr;
    logic        mem_valid = 1'b0;
    logic [7:0]  mem_rdata = '0;

    int n_chk = 0;
    int n_bad = 0;
    int lat_max = 0;
    int lat_fix = -1;
    int lat_cnt = 0;
    int fetch_cnt = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    hxfer_ctrl u_dut (.*);

    function automatic logic [7:0] mem_byte(input logic [15:0] a);
        return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h5A;
    endfunction

    function automatic int next_lat();
        if (lat_fix >= 0) return lat_fix;
        return int'($urandom % (lat_max + 1));
    endfunction

    always @(negedge clk) begin
        if (mem_req && lat_cnt == 0) begin
            mem_valid = 1'b1;
            mem_rdata = mem_byte(mem_addr);
            fetch_cnt++;
            lat_cnt = next_lat();
        end else begin
            mem_valid = 1'b0;
            if (mem_req) lat_cnt--;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic cpu_write(input logic [2:0] s, input logic [7:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_sel = s; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
        #1;
    endtask

    task automatic run_xfer(input int cnt, input logic [15:0] adr, input bit dmode,
                            input int max_gap, input bit no_wait, input bit first_wait,
                            input bit retrig);
        int n;
        int f0;
        bit saw_wait;
        n = cnt + 1;
        drq_mode = dmode;
        cpu_write(3'd0, cnt[7:0]);
        cpu_write(3'd1, {4'h0, cnt[11:8]});
        cpu_write(3'd2, adr[7:0]);
        cpu_write(3'd3, adr[15:8]);
        f0 = fetch_cnt;
        cpu_write(3'd4, 8'($urandom));
        check(busy && !xfer_en_n, "R2 start", {busy, xfer_en_n}, 2'b10);
        for (int k = 0; k < n; k++) begin
            if (retrig && k == 2) begin
                cpu_write(3'd0, 8'h03);
                cpu_write(3'd4, 8'h00);
                check(busy, "R9 busy kept", busy, 1);
            end
            repeat (int'($urandom % (max_gap + 1))) begin
                @(negedge clk); #1;
            end
            if (dmode) begin
                while (!drq) begin @(negedge clk); #1; end
            end else begin
                check(!drq, "R10 drq strobe mode", drq, 0);
            end
            @(negedge clk);
            host_rd = 1'b1;
            #1;
            saw_wait = 0;
            while (!host_wait_n) begin
                saw_wait = 1;
                check(eop == (k == n - 1), "R6 eop in wait", eop, (k == n - 1));
                @(negedge clk); #1;
            end
            check(host_data == mem_byte(adr + 16'(k)), "R3 data", host_data, mem_byte(adr + 16'(k)));
            check(eop == (k == n - 1), "R6 eop", eop, (k == n - 1));
            if (no_wait && k > 0) check(!saw_wait, "R4 no wait", saw_wait, 0);
            if (first_wait && k == 0) check(saw_wait, "R4 wait seen", saw_wait, 1);
            repeat (int'($urandom % 3)) begin
                @(negedge clk); #1;
                check(host_wait_n && !eop, "R5 held strobe", {host_wait_n, eop}, 2'b10);
            end
            @(negedge clk);
            host_rd = 1'b0;
            #1;
        end
        check(!busy && xfer_en_n && irq, "R7 end", {busy, xfer_en_n, irq}, 3'b011);
        check(fetch_cnt - f0 == n, "R11 fetches", fetch_cnt - f0, n);
        check(!drq, "R10 drq idle", drq, 0);
        cpu_write(3'd5, 8'h00);
        check(!irq, "R8 ack", irq, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        int f0;
        void'($urandom(32'h00C0FFEE));
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        check(xfer_en_n && host_wait_n && !busy && !irq && !drq && !eop && !mem_req,
              "R1 reset", {xfer_en_n, host_wait_n, busy, irq, drq, eop, mem_req}, 7'b1100000);

        // R12 strobe while idle
        f0 = fetch_cnt;
        @(negedge clk); host_rd = 1'b1; #1;
        check(host_wait_n && !eop && !mem_req, "R12 idle strobe", {host_wait_n, eop, mem_req}, 3'b100);
        @(negedge clk); #1;
        @(negedge clk); host_rd = 1'b0; #1;
        check(fetch_cnt == f0 && !busy, "R12 no fetch", fetch_cnt - f0, 0);

        // one byte
        lat_max = 0; lat_fix = -1;
        run_xfer(0, 16'h1234, 0, 1, 1, 0, 0);
        // slow memory, first strobe waits
        lat_fix = 5; lat_cnt = 5;
        run_xfer(3, 16'h0100, 0, 0, 0, 1, 0);
        lat_fix = -1; lat_cnt = 0;
        // address wrap
        run_xfer(3, 16'hFFFE, 0, 2, 1, 0, 0);
        // trigger while busy
        lat_max = 2;
        run_xfer(5, 16'h4000, 0, 2, 0, 0, 1);
        // request mode
        run_xfer(7, 16'h8001, 1, 2, 0, 0, 0);
        // random runs
        for (int i = 0; i < 14; i++) begin
            lat_max = int'($urandom % 4);
            run_xfer(int'($urandom % 41), 16'($urandom), 1'($urandom),
                     int'($urandom % 4), 0, 0, 1'($urandom));
        end
        // full count
        lat_max = 0; lat_cnt = 0;
        run_xfer(12'hFFF, 16'h2000, 0, 0, 1, 0, 0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule